// File: doc/BRIEF.md
# Master Clock Rate Detector

This block works out, with no configuration input, which of three master clock frequencies (2.048 MHz, 4.096 MHz or 8.192 MHz) is driving it. It measures that clock against the frame sync reference, which repeats every 125 µs (8000 frames per second). It counts master clock cycles between successive frame sync rising edges and sorts each count into a nominal 256, 512 or 1024 cycle window. Each window allows ±4 cycles.

A small state machine accepts a classification only after two consecutive measurements agree. It then presents a two-bit rate code with a valid flag. Downstream timing uses the code to choose its internal divide ratio. Any of these conditions raises an error flag:
- a count outside every window;
- no frame sync edge for 2048 cycles.

The frame sync input is asynchronous. It passes through a two-flop synchronizer before its rising edge is detected.

States:
- `ST_IDLE`: waits for the first reference edge after reset.
- `ST_FIRST`: waits for the first full measurement.
- `ST_CONFIRM`: holds a candidate code and waits for a second, matching measurement.
- `ST_LOCKED`: presents the code with valid high.
- `ST_FAULT`: entered on an out-of-window count.
- `ST_LOST`: entered on a frame sync timeout.

Transitions:
- IDLE or LOST to FIRST on an edge.
- Any state to LOST on a timeout with no edge in the same cycle.
- FIRST, CONFIRM, LOCKED or FAULT to FAULT on an out-of-window measurement.
- FIRST or FAULT to CONFIRM on an in-window measurement.
- CONFIRM to LOCKED on a measurement equal to the candidate.
- CONFIRM to CONFIRM, loading a new candidate, on a different in-window measurement.
- LOCKED to CONFIRM on a different in-window measurement.
- LOCKED to LOCKED on a matching measurement.

Top module: `mclk_rate_detect`

## Requirements
- R1: Reset state:
  - While `rst_ni` is low, and after its release until an event occurs: `rate_o` = 2'b11, `valid_o` = 0, `error_o` = 0.
- R2: Timing:
  - The period is the number of master clock cycles between two consecutive frame sync rising edges.
  - Outputs react at the third master clock rising edge after the frame sync input rises.
- R3: Rate codes, each for a period within ±4 cycles of its nominal count:
  - 256 cycles maps to 2'b00.
  - 512 cycles maps to 2'b01.
  - 1024 cycles maps to 2'b10.
- R4: Out-of-window measurement:
  - A measured period outside every window sets `error_o` = 1, `valid_o` = 0 and `rate_o` = 2'b11.
  - The next in-window measurement clears `error_o`.
  - Example: 251 or 261 cycles is out of window.
- R5: Locking:
  - `valid_o` rises only after two consecutive measurements give the same code.
  - The first edge after reset or after a timeout is a reference only and gives no measurement.
  - A candidate replaced by a different code must itself be repeated.
- R6: Leaving lock:
  - While locked, one in-window measurement with a different code drops `valid_o`.
  - A second equal measurement locks to the new code.
- R7: Timeout:
  - If no frame sync edge is seen for 2048 master clock cycles, then `valid_o` = 0, `error_o` = 1 and `rate_o` = 2'b11.
  - The next edge clears `error_o` and restarts from the reference stage.
- R8: While locked, measurements in the same window keep `valid_o` high and `rate_o` unchanged. This includes the window edges, for example 252 and 260 cycles for 2'b00.
- R9: Whenever `valid_o` is 0, `rate_o` is 2'b11. Whenever `valid_o` is 1, `rate_o` is never 2'b11, and `error_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock being measured |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| fsync_i | input | 1 | Frame sync reference (8 kHz), asynchronous |
| rate_o | output | 2 | Detected rate code; 2'b11 when unknown |
| valid_o | output | 1 | High while the rate code is locked |
| error_o | output | 1 | High after an out-of-window count or a timeout |

## Verification
The bench drives frame sync on falling clock edges. Every output change caused by a rising edge is therefore due at the third master clock rising edge after it: two synchronizer flops, then the state register. One check samples the falling edges just before and just after that point to pin down the latency.

All other checks sample four falling edges after the rise, which is well past the update and well before the next pulse. The measured period is set directly by the gap between the bench's rising edges.

For the timeout, the bench checks once about 2000 cycles after the last edge, while the design is still locked. It checks again after about 2100 cycles, when loss must be reported.

// File: rtl/mcrd_pkg.sv
package mcrd_pkg;

    typedef enum logic [1:0] {
        RATE_2M   = 2'b00,
        RATE_4M   = 2'b01,
        RATE_8M   = 2'b10,
        RATE_NONE = 2'b11
    } rate_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FIRST   = 3'd1,
        ST_CONFIRM = 3'd2,
        ST_LOCKED  = 3'd3,
        ST_FAULT   = 3'd4,
        ST_LOST    = 3'd5
    } state_e;

endpackage

// File: rtl/fs_edge_sync.sv
module fs_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] stage_q;
    logic         prev_q;

    generate
        if (SYNC_STAGES < 2) begin : g_bad
            initial $error("fs_edge_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stage_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            stage_q <= {stage_q[MSB-1:0], async_i};
            prev_q  <= stage_q[MSB];
        end
    end

    assign rise_o = stage_q[MSB] & ~prev_q;

endmodule

// File: rtl/frame_period_counter.sv
module frame_period_counter #(
    parameter int LIMIT = 2048,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    // Count restarts at one on each edge, so the value seen at the next
    // edge equals the number of cycles between the two edges.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (edge_i) begin
            count_q <= ONE_C;
        end else if (count_q != LIMIT_C) begin
            count_q <= count_q + ONE_C;
        end
    end

    assign count_o   = count_q;
    assign timeout_o = (count_q == LIMIT_C);

endmodule

// File: rtl/rate_classifier.sv
module rate_classifier
    import mcrd_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int BASE_COUNT = 256,
    parameter int TOLERANCE  = 4,
    parameter int NUM_RATES  = 3
) (
    input  logic [CNT_W-1:0] count_i,
    output rate_e            rate_o
);
    logic [NUM_RATES-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_RATES; i++) begin : g_win
            localparam int NOMINAL = BASE_COUNT << i;
            localparam logic [CNT_W-1:0] LO = CNT_W'(NOMINAL - TOLERANCE);
            localparam logic [CNT_W-1:0] HI = CNT_W'(NOMINAL + TOLERANCE);
            assign hit[i] = (count_i >= LO) && (count_i <= HI);
        end
    endgenerate

    // Windows do not overlap, so at most one bit of hit is set.
    always_comb begin
        rate_o = RATE_NONE;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (hit[i]) begin
                rate_o = rate_e'(2'(i));
            end
        end
    end

endmodule

// File: rtl/rate_lock_fsm.sv
module rate_lock_fsm
    import mcrd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       edge_i,
    input  logic       timeout_i,
    input  rate_e      meas_i,
    output logic [1:0] rate_o,
    output logic       valid_o,
    output logic       error_o
);
    state_e state_q, state_d;
    rate_e  cand_q, cand_d;
    logic   known;

    assign known = (meas_i != RATE_NONE);

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Candidate code register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cand_q <= RATE_NONE;
        end else begin
            cand_q <= cand_d;
        end
    end

    // Next state. An edge always takes priority over a timeout.
    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        unique case (state_q)
            ST_IDLE, ST_LOST: begin
                if (edge_i) begin
                    state_d = ST_FIRST;
                end else if (timeout_i) begin
                    state_d = ST_LOST;
                end
            end
            ST_FIRST, ST_FAULT: begin
                if (edge_i) begin
                    if (!known) begin
                        state_d = ST_FAULT;
                    end else begin
                        cand_d  = meas_i;
                        state_d = ST_CONFIRM;
                    end
                end else if (timeout_i) begin
                    state_d = ST_LOST;
                end
            end
            ST_CONFIRM: begin
                if (edge_i) begin
                    if (!known) begin
                        state_d = ST_FAULT;
                    end else if (meas_i == cand_q) begin
                        state_d = ST_LOCKED;
                    end else begin
                        cand_d  = meas_i;
                        state_d = ST_CONFIRM;
                    end
                end else if (timeout_i) begin
                    state_d = ST_LOST;
                end
            end
            ST_LOCKED: begin
                if (edge_i) begin
                    if (!known) begin
                        state_d = ST_FAULT;
                    end else if (meas_i != cand_q) begin
                        cand_d  = meas_i;
                        state_d = ST_CONFIRM;
                    end
                end else if (timeout_i) begin
                    state_d = ST_LOST;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs, decoded from the registered state.
    always_comb begin
        rate_o  = RATE_NONE;
        valid_o = 1'b0;
        error_o = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                rate_o  = cand_q;
                valid_o = 1'b1;
            end
            ST_FAULT, ST_LOST: begin
                error_o = 1'b1;
            end
            default: begin
                rate_o = RATE_NONE;
            end
        endcase
    end

endmodule

// File: rtl/mclk_rate_detect.sv
module mclk_rate_detect
    import mcrd_pkg::*;
#(
    parameter int BASE_COUNT     = 256,
    parameter int TOLERANCE      = 4,
    parameter int TIMEOUT_CYCLES = 2048,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fsync_i,
    output logic [1:0] rate_o,
    output logic       valid_o,
    output logic       error_o
);
    localparam int NUM_RATES = 3;
    localparam int CNT_W     = $clog2(TIMEOUT_CYCLES + 1);

    logic             fs_edge;
    logic [CNT_W-1:0] period_cnt;
    logic             timeout_hit;
    rate_e            meas_rate;

    fs_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(fsync_i),
        .rise_o (fs_edge)
    );

    frame_period_counter #(
        .LIMIT(TIMEOUT_CYCLES),
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .edge_i   (fs_edge),
        .count_o  (period_cnt),
        .timeout_o(timeout_hit)
    );

    rate_classifier #(
        .CNT_W     (CNT_W),
        .BASE_COUNT(BASE_COUNT),
        .TOLERANCE (TOLERANCE),
        .NUM_RATES (NUM_RATES)
    ) u_cls (
        .count_i(period_cnt),
        .rate_o (meas_rate)
    );

    rate_lock_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .edge_i   (fs_edge),
        .timeout_i(timeout_hit),
        .meas_i   (meas_rate),
        .rate_o   (rate_o),
        .valid_o  (valid_o),
        .error_o  (error_o)
    );

endmodule

// File: rtl/mcrd_checker.sv
module mcrd_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       edge_i,
    input logic       timeout_i,
    input logic [1:0] rate_i,
    input logic       valid_i,
    input logic       error_i
);
    // R9: an unknown code is never presented as valid.
    assert_code_known_when_valid_R9: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> (rate_i != 2'b11));

    // R9: the unknown code is shown whenever valid is low.
    assert_unknown_when_invalid_R9: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> (rate_i == 2'b11));

    // R4: error and valid are never high together.
    assert_error_excludes_valid_R4: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !(valid_i && error_i));

    // R5: lock is only gained on a frame sync edge.
    assert_lock_on_edge_R5: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_i) |-> $past(edge_i));

    // R7: a timeout with no edge reports an error in the next cycle.
    assert_timeout_reports_R7: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (timeout_i && !edge_i) |=> (error_i && !valid_i));

    // R8: the code stays steady while lock is held.
    assert_rate_steady_locked_R8: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (valid_i && $past(valid_i)) |-> $stable(rate_i));

endmodule

bind mclk_rate_detect mcrd_checker u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (fs_edge),
    .timeout_i(timeout_hit),
    .rate_i   (rate_o),
    .valid_i  (valid_o),
    .error_i  (error_o)
);

// File: tb/sim_mclk_rate_detect.sv
`timescale 1ns/1ps
module sim_mclk_rate_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [1:0] rate;
    logic       valid;
    logic       error;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mclk_rate_detect u0 (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .fsync_i(fsync),
        .rate_o (rate),
        .valid_o(valid),
        .error_o(error)
    );

    task automatic expect_out(input logic [1:0] er, input logic ev,
                              input logic ee, input string req);
        checks++;
        if (rate !== er || valid !== ev || error !== ee) begin
            failures++;
            $display("FAIL %s: got rate=%b valid=%b error=%b expected rate=%b valid=%b error=%b",
                     req, rate, valid, error, er, ev, ee);
        end
    endtask

    // Rising edge of fsync comes gap cycles after the previous one.
    task automatic pulse(input int gap);
        repeat (gap - 4) @(negedge clk);
        fsync = 1'b1;
        repeat (4) @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        expect_out(2'b11, 1'b0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_out(2'b11, 1'b0, 1'b0, "R1 after release");
    endtask

    task automatic t_lock_2m();
        pulse(20);
        expect_out(2'b11, 1'b0, 1'b0, "R5 reference edge gives no measurement");
        pulse(256);
        expect_out(2'b11, 1'b0, 1'b0, "R5 single measurement not valid");
        // Third pulse: check exact latency (R2).
        repeat (256 - 4) @(negedge clk);
        fsync = 1'b1;
        repeat (2) @(negedge clk);
        expect_out(2'b11, 1'b0, 1'b0, "R2 no change before third edge");
        @(negedge clk);
        expect_out(2'b00, 1'b1, 1'b0, "R2 R3 lock 2.048 at third edge");
        @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic t_window_edges();
        pulse(252);
        expect_out(2'b00, 1'b1, 1'b0, "R8 low edge 252 keeps lock");
        pulse(260);
        expect_out(2'b00, 1'b1, 1'b0, "R8 high edge 260 keeps lock");
    endtask

    task automatic t_fault();
        pulse(251);
        expect_out(2'b11, 1'b0, 1'b1, "R4 count 251 rejected");
        pulse(261);
        expect_out(2'b11, 1'b0, 1'b1, "R4 count 261 rejected");
        pulse(256);
        expect_out(2'b11, 1'b0, 1'b0, "R4 in-window count clears error");
        pulse(256);
        expect_out(2'b00, 1'b1, 1'b0, "R4 relock after fault");
    endtask

    task automatic t_switch_4m();
        pulse(512);
        expect_out(2'b11, 1'b0, 1'b0, "R6 one differing count drops lock");
        pulse(516);
        expect_out(2'b01, 1'b1, 1'b0, "R6 R3 lock 4.096 with +4 count");
    endtask

    task automatic t_candidate_swap();
        pulse(1024);
        expect_out(2'b11, 1'b0, 1'b0, "R6 drop lock on 8.192 count");
        pulse(256);
        expect_out(2'b11, 1'b0, 1'b0, "R5 new candidate needs repeat");
        pulse(256);
        expect_out(2'b00, 1'b1, 1'b0, "R5 lock after two equal counts");
    endtask

    task automatic t_lock_8m();
        pulse(1020);
        expect_out(2'b11, 1'b0, 1'b0, "R9 unknown code while confirming");
        pulse(1028);
        expect_out(2'b10, 1'b1, 1'b0, "R3 lock 8.192 across tolerance");
    endtask

    task automatic t_timeout();
        repeat (2000) @(negedge clk);
        expect_out(2'b10, 1'b1, 1'b0, "R7 still locked before limit");
        repeat (100) @(negedge clk);
        expect_out(2'b11, 1'b0, 1'b1, "R7 loss after 2048 silent cycles");
        pulse(8);
        expect_out(2'b11, 1'b0, 1'b0, "R7 edge clears error, reference only");
        pulse(508);
        expect_out(2'b11, 1'b0, 1'b0, "R7 R5 first count after loss");
        pulse(512);
        expect_out(2'b01, 1'b1, 1'b0, "R7 relock 4.096 after loss");
    endtask

    initial begin
        t_reset();
        t_lock_2m();
        t_window_edges();
        t_fault();
        t_switch_4m();
        t_candidate_swap();
        t_lock_8m();
        t_timeout();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule